// File: doc/BRIEF.md
# Wakeup Event Status Controller

This block gathers wake events from three sources: a consumer-IR receiver, the ring-indicate line of a second serial port, and the data input of an audio codec. Each source arrives as a pulse or level on its own input. The block passes each input through a two-stage synchronizer and an edge detector, then latches it into a sticky status bit. Software clears a status bit by writing a one to it.

Each source also has an enable bit. When a status bit is set and its enable bit is set, the block raises a single wake output. That output drives both the power-up request and the power-management-event notification.

Software reaches the block through a byte-wide register port with a combinational read path. The port exposes three registers: the status register, an enable register and a configuration register. The configuration register holds a two-bit bank selector. The consumer-IR register bank is a small set of byte registers that feed the IR receiver. That bank can be read or written only while the selector holds the IR-bank code.

Top module: `wake_evt_ctrl`

## Requirements
- R1: After synchronous reset, the status register reads 00h, the enable register reads 03h and the configuration register reads 00h, and `wake_o` is low.
- R2: The status register sits at address 00h, the configuration register at 01h and the enable register at 02h. Any address that maps to no register reads 00h.
- R3: In the status register, bit 5 is the IR event, bit 1 is the ring-indicate event and bit 0 is the codec event. Suppose an event input is first sampled high at clock edge k. Its status bit then reads 1 after edge k+2 and stays 1 until software clears it.
- R4: Writing to address 00h clears each status bit whose data bit is 1. A status bit whose data bit is 0 is left unchanged.
- R5: A clear of a status bit and a new detected edge of that bit's source can land on the same clock edge. In that case the bit stays set.
- R6: In the enable register, bit 5 enables the IR event, bit 1 enables the ring-indicate event and bit 0 enables the codec event. These bits are read/write. All other bits of the register read 0.
- R7: `wake_o` is high exactly when some status bit is set and its enable bit is also set. It follows register changes with no added delay.
- R8: An event whose enable bit is clear still sets its status bit but does not raise `wake_o`. Setting that enable bit later raises `wake_o`.
- R9: Configuration bits 1:0 form the bank selector and are read/write. They also appear on `bank_sel_o`. The codes are 00 = shared registers only, 01 = shared registers plus the IR bank, 10 = another bank, 11 = reserved. Configuration bits 7:2 read 0.
- R10: The IR bank occupies IR_REGS bytes starting at address 10h. Byte i appears on `ir_bank_o[8i+7:8i]`, and every byte resets to 00h. While the selector is 01, those addresses can be read and written. While the selector holds any other code, those addresses read 00h and writes to them are ignored.
- R11: An event input held high sets its status bit only once. After software clears the bit, it stays clear for as long as the input stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_codec_i | input | 1 | Audio codec data-input event |
| ev_ring_i | input | 1 | Second serial port ring-indicate event |
| ev_ir_i | input | 1 | Consumer-IR receiver event |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Read data for `reg_addr_i` (combinational) |
| wake_o | output | 1 | Power-up request and power-management event |
| bank_sel_o | output | 2 | Current bank selector |
| ir_bank_o | output | 8*IR_REGS | IR bank register contents |

## Verification
Faults in this block show up in two places: on `wake_o` in the same cycle, and on a status read one cycle after the state goes wrong. Two kinds of fault show up on `wake_o` directly. The first is a lost edge in the synchronizer, which leaves the wake output low two edges after an enabled event. The second is a clear that wins over a simultaneous event, which drops the wake output one cycle after the write. A faulty bank gate can silently corrupt an IR bank byte. That corruption appears on `ir_bank_o` right after the write edge, so it is compared every cycle. A wrong reset enable shows up on the first read of address 02h.

// File: rtl/wake_evt_pkg.sv
package wake_evt_pkg;

    localparam int NUM_SRC = 3;

    // Compact source index used throughout the datapath
    typedef enum logic [1:0] {
        SRC_CODEC = 2'd0,
        SRC_RING  = 2'd1,
        SRC_IR    = 2'd2
    } src_e;

    localparam logic [7:0] ADDR_STATUS = 8'h00;
    localparam logic [7:0] ADDR_CFG    = 8'h01;
    localparam logic [7:0] ADDR_ENABLE = 8'h02;

    localparam logic [NUM_SRC-1:0] ENABLE_RST = 3'b011;

    typedef enum logic [1:0] {
        BANK_SHARED = 2'b00,
        BANK_IR     = 2'b01,
        BANK_OTHER  = 2'b10,
        BANK_RSVD   = 2'b11
    } bank_e;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_STATUS,
        SEL_CFG,
        SEL_ENABLE,
        SEL_IRBANK
    } sel_e;

    typedef struct packed {
        logic       we;
        logic [7:0] addr;
        logic [7:0] data;
    } reg_req_t;

    // Bit position of a source inside the byte-wide status/enable registers
    function automatic int src_pos(input int idx);
        case (idx)
            0:       return 0;
            1:       return 1;
            default: return 5;
        endcase
    endfunction

    function automatic logic [7:0] expand(input logic [NUM_SRC-1:0] v);
        logic [7:0] r;
        r = '0;
        for (int i = 0; i < NUM_SRC; i++) r[src_pos(i)] = v[i];
        return r;
    endfunction

    function automatic logic [NUM_SRC-1:0] compress(input logic [7:0] b);
        logic [NUM_SRC-1:0] r;
        for (int i = 0; i < NUM_SRC; i++) r[i] = b[src_pos(i)];
        return r;
    endfunction

endpackage

// File: rtl/wake_evt_sync.sv
module wake_evt_sync #(
    parameter int N      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] ev_i,
    output logic [N-1:0] rise_o
);
    localparam int DEPTH = STAGES + 1;

    for (genvar g = 0; g < N; g++) begin : g_src
        logic [DEPTH-1:0] pipe;
        always_ff @(posedge clk) begin
            if (rst) pipe <= '0;
            else     pipe <= {pipe[DEPTH-2:0], ev_i[g]};
        end
        // last synchronized sample high, one stage later still low
        assign rise_o[g] = pipe[STAGES-1] & ~pipe[STAGES];
    end
endmodule

// File: rtl/wake_evt_decode.sv
module wake_evt_decode
    import wake_evt_pkg::*;
#(
    parameter logic [7:0] IR_BASE = 8'h10,
    parameter int         IR_REGS = 4,
    localparam int        IDX_W   = (IR_REGS > 1) ? $clog2(IR_REGS) : 1
) (
    input  logic [7:0]       addr_i,
    input  bank_e            bank_i,
    output sel_e             sel_o,
    output logic [IDX_W-1:0] ir_idx_o
);
    logic [8:0] off;
    logic       in_ir;

    assign off      = {1'b0, addr_i} - {1'b0, IR_BASE};
    assign in_ir    = (addr_i >= IR_BASE) && (off < 9'(IR_REGS));
    assign ir_idx_o = off[IDX_W-1:0];

    always_comb begin
        sel_o = SEL_NONE;
        if (addr_i == ADDR_STATUS)      sel_o = SEL_STATUS;
        else if (addr_i == ADDR_CFG)    sel_o = SEL_CFG;
        else if (addr_i == ADDR_ENABLE) sel_o = SEL_ENABLE;
        else if (in_ir && bank_i == BANK_IR) sel_o = SEL_IRBANK;
    end
endmodule

// File: rtl/wake_evt_regs.sv
module wake_evt_regs
    import wake_evt_pkg::*;
#(
    parameter int  IR_REGS = 4,
    localparam int IDX_W   = (IR_REGS > 1) ? $clog2(IR_REGS) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  reg_req_t             req_i,
    input  sel_e                 sel_i,
    input  logic [IDX_W-1:0]     ir_idx_i,
    input  logic [NUM_SRC-1:0]   rise_i,
    output logic [7:0]           rdata_o,
    output logic [NUM_SRC-1:0]   status_o,
    output logic [NUM_SRC-1:0]   enable_o,
    output bank_e                bank_o,
    output logic [8*IR_REGS-1:0] ir_bank_o
);
    logic [NUM_SRC-1:0] status_q, enable_q, clr;
    bank_e              bank_q;
    logic [7:0]         ir_q [IR_REGS];

    assign clr = (req_i.we && sel_i == SEL_STATUS) ? compress(req_i.data) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= '0;
            enable_q <= ENABLE_RST;
            bank_q   <= BANK_SHARED;
        end else begin
            // a fresh edge wins over a simultaneous clear
            status_q <= (status_q & ~clr) | rise_i;
            if (req_i.we && sel_i == SEL_ENABLE) enable_q <= compress(req_i.data);
            if (req_i.we && sel_i == SEL_CFG)    bank_q   <= bank_e'(req_i.data[1:0]);
        end
    end

    for (genvar g = 0; g < IR_REGS; g++) begin : g_ir
        always_ff @(posedge clk) begin
            if (rst) ir_q[g] <= '0;
            else if (req_i.we && sel_i == SEL_IRBANK && ir_idx_i == IDX_W'(g))
                ir_q[g] <= req_i.data;
        end
        assign ir_bank_o[8*g +: 8] = ir_q[g];
    end

    always_comb begin
        rdata_o = '0;
        case (sel_i)
            SEL_STATUS: rdata_o = expand(status_q);
            SEL_CFG:    rdata_o = {6'b0, bank_q};
            SEL_ENABLE: rdata_o = expand(enable_q);
            SEL_IRBANK: rdata_o = ir_q[ir_idx_i];
            default:    rdata_o = '0;
        endcase
    end

    assign status_o = status_q;
    assign enable_o = enable_q;
    assign bank_o   = bank_q;
endmodule

// File: rtl/wake_evt_ctrl.sv
module wake_evt_ctrl
    import wake_evt_pkg::*;
#(
    parameter logic [7:0] IR_BASE     = 8'h10,
    parameter int         IR_REGS     = 4,
    parameter int         SYNC_STAGES = 2,
    localparam int        IDX_W       = (IR_REGS > 1) ? $clog2(IR_REGS) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ev_codec_i,
    input  logic                 ev_ring_i,
    input  logic                 ev_ir_i,
    input  logic                 reg_we_i,
    input  logic [7:0]           reg_addr_i,
    input  logic [7:0]           reg_wdata_i,
    output logic [7:0]           reg_rdata_o,
    output logic                 wake_o,
    output logic [1:0]           bank_sel_o,
    output logic [8*IR_REGS-1:0] ir_bank_o
);
    logic [NUM_SRC-1:0] ev_vec, rise, status, enable;
    reg_req_t           req;
    sel_e               sel;
    bank_e              bank;
    logic [IDX_W-1:0]   ir_idx;

    assign ev_vec[SRC_CODEC] = ev_codec_i;
    assign ev_vec[SRC_RING]  = ev_ring_i;
    assign ev_vec[SRC_IR]    = ev_ir_i;
    assign req = '{we: reg_we_i, addr: reg_addr_i, data: reg_wdata_i};

    wake_evt_sync #(.N(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .ev_i(ev_vec), .rise_o(rise)
    );

    wake_evt_decode #(.IR_BASE(IR_BASE), .IR_REGS(IR_REGS)) u_dec (
        .addr_i(reg_addr_i), .bank_i(bank), .sel_o(sel), .ir_idx_o(ir_idx)
    );

    wake_evt_regs #(.IR_REGS(IR_REGS)) u_regs (
        .clk(clk), .rst(rst), .req_i(req), .sel_i(sel), .ir_idx_i(ir_idx),
        .rise_i(rise), .rdata_o(reg_rdata_o), .status_o(status),
        .enable_o(enable), .bank_o(bank), .ir_bank_o(ir_bank_o)
    );

    assign wake_o     = |(status & enable);
    assign bank_sel_o = bank;
endmodule

// File: rtl/wake_evt_ctrl_chk.sv
module wake_evt_ctrl_chk
    import wake_evt_pkg::*;
#(
    parameter logic [7:0] IR_BASE = 8'h10,
    parameter int         IR_REGS = 4
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 reg_we,
    input logic [7:0]           reg_addr,
    input logic [7:0]           reg_wdata,
    input logic                 wake,
    input logic [NUM_SRC-1:0]   rise,
    input logic [NUM_SRC-1:0]   status,
    input logic [1:0]           bank,
    input logic [8*IR_REGS-1:0] ir_bank
);
    logic ir_addr;
    assign ir_addr = (int'(reg_addr) >= int'(IR_BASE)) &&
                     (int'(reg_addr) <  int'(IR_BASE) + IR_REGS);

    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!wake && status == '0));

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_bit
        // R3 and R5: a detected edge always leaves its bit set
        assert_edge_sets_R3: assert property (@(posedge clk) disable iff (rst)
            rise[g] |=> status[g]);
        assert_w1c_clears_R4: assert property (@(posedge clk) disable iff (rst)
            (reg_we && reg_addr == ADDR_STATUS && reg_wdata[src_pos(g)] && !rise[g])
            |=> !status[g]);
    end

    assert_wake_drop_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(wake) |-> $past(reg_we));

    assert_wake_rise_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(wake) |-> ($past(reg_we) || $past(rise) != '0));

    assert_bank_locked_R10: assert property (@(posedge clk) disable iff (rst)
        (reg_we && ir_addr && bank != BANK_IR) |=> $stable(ir_bank));
endmodule

bind wake_evt_ctrl wake_evt_ctrl_chk #(.IR_BASE(IR_BASE), .IR_REGS(IR_REGS)) u_chk (
    .clk(clk), .rst(rst), .reg_we(reg_we_i), .reg_addr(reg_addr_i),
    .reg_wdata(reg_wdata_i), .wake(wake_o), .rise(rise), .status(status),
    .bank(bank_sel_o), .ir_bank(ir_bank_o)
);

// File: tb/wake_evt_ctrl_bench.sv
`timescale 1ns/1ps
module wake_evt_ctrl_bench;
    localparam int NREG = 4;

    logic clk = 0, rst = 1;
    logic ev_codec = 0, ev_ring = 0, ev_ir = 0;
    logic we = 0;
    logic [7:0] addr = 0, wdata = 0;
    logic [7:0] rdata;
    logic wake;
    logic [1:0] bank_sel;
    logic [8*NREG-1:0] ir_bank;

    int checks = 0, fails = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    wake_evt_ctrl u_wake_evt_ctrl (
        .clk(clk), .rst(rst), .ev_codec_i(ev_codec), .ev_ring_i(ev_ring),
        .ev_ir_i(ev_ir), .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
        .reg_rdata_o(rdata), .wake_o(wake), .bank_sel_o(bank_sel), .ir_bank_o(ir_bank)
    );

    // behavioural reference: index 0 codec, 1 ring, 2 IR
    bit   m_st[3], m_en[3];
    int   m_bank;
    byte  m_ir[NREG];
    bit   d1[3], d2[3], d3[3];

    function automatic int pos(int i);
        return (i == 0) ? 0 : (i == 1) ? 1 : 5;
    endfunction

    function automatic bit [7:0] mread(bit [7:0] a);
        bit [7:0] r = 0;
        if (a == 8'h00) begin
            for (int i = 0; i < 3; i++) r[pos(i)] = m_st[i];
        end else if (a == 8'h01) r = 8'(m_bank);
        else if (a == 8'h02) begin
            for (int i = 0; i < 3; i++) r[pos(i)] = m_en[i];
        end else if (a >= 8'h10 && a < 8'h10 + NREG && m_bank == 1) r = m_ir[a - 8'h10];
        return r;
    endfunction

    function automatic bit mwake();
        bit w = 0;
        for (int i = 0; i < 3; i++) w |= m_st[i] & m_en[i];
        return w;
    endfunction

    task automatic model_edge();
        bit ev[3];
        bit rise[3];
        int old_bank;
        ev[0] = ev_codec; ev[1] = ev_ring; ev[2] = ev_ir;
        if (rst) begin
            for (int i = 0; i < 3; i++) begin
                m_st[i] = 0; d1[i] = 0; d2[i] = 0; d3[i] = 0;
            end
            m_en[0] = 1; m_en[1] = 1; m_en[2] = 0; m_bank = 0;
            for (int i = 0; i < NREG; i++) m_ir[i] = 0;
            return;
        end
        old_bank = m_bank;
        for (int i = 0; i < 3; i++) rise[i] = d2[i] && !d3[i];
        for (int i = 0; i < 3; i++) begin
            if (we && addr == 8'h00 && wdata[pos(i)]) m_st[i] = 0;
            if (rise[i]) m_st[i] = 1;
            if (we && addr == 8'h02) m_en[i] = wdata[pos(i)];
        end
        if (we && addr == 8'h01) m_bank = int'(wdata[1:0]);
        if (we && addr >= 8'h10 && addr < 8'h10 + NREG && old_bank == 1)
            m_ir[addr - 8'h10] = wdata;
        for (int i = 0; i < 3; i++) begin
            d3[i] = d2[i]; d2[i] = d1[i]; d1[i] = ev[i];
        end
    endtask

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic compare_all();
        logic [8*NREG-1:0] exp_ir;
        for (int i = 0; i < NREG; i++) exp_ir[8*i +: 8] = m_ir[i];
        check("R7 wake", {31'b0, wake}, {31'b0, mwake()});
        check("R2 rdata", {24'b0, rdata}, {24'b0, mread(addr)});
        check("R10 ir_bank", ir_bank, exp_ir);
        check("R9 bank_sel", {30'b0, bank_sel}, 32'(m_bank));
    endtask

    task automatic cyc();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare_all();
    endtask

    task automatic idle(int n);
        we = 0;
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic wr(bit [7:0] a, bit [7:0] d);
        we = 1; addr = a; wdata = d;
        cyc();
        we = 0;
    endtask

    task automatic rd_chk(string tag, bit [7:0] a, bit [7:0] exp);
        we = 0; addr = a;
        #1;
        check(tag, {24'b0, rdata}, {24'b0, exp});
    endtask

    initial begin
        rst = 1;
        idle(3);
        rst = 0;
        // R1 reset values
        rd_chk("R1 status", 8'h00, 8'h00);
        rd_chk("R1 enable", 8'h02, 8'h03);
        rd_chk("R1 cfg", 8'h01, 8'h00);
        check("R1 wake", {31'b0, wake}, 0);
        idle(1);

        // R3 codec pulse: visible after edge k+2
        ev_codec = 1; cyc(); ev_codec = 0; cyc();
        rd_chk("R3 not yet", 8'h00, 8'h00);
        cyc();
        rd_chk("R3 status codec", 8'h00, 8'h01);
        check("R7 wake on", {31'b0, wake}, 1);
        idle(4);
        rd_chk("R3 sticky", 8'h00, 8'h01);

        // R4 write-zero no effect, write-one clears
        wr(8'h00, 8'h00);
        rd_chk("R4 zero write", 8'h00, 8'h01);
        wr(8'h00, 8'h01);
        rd_chk("R4 cleared", 8'h00, 8'h00);
        check("R7 wake off", {31'b0, wake}, 0);

        // R11 held level sets once
        ev_ring = 1; idle(5);
        rd_chk("R11 ring set", 8'h00, 8'h02);
        wr(8'h00, 8'h02);
        idle(5);
        rd_chk("R11 held no reset", 8'h00, 8'h00);
        ev_ring = 0; idle(4);

        // R8 disabled IR event
        ev_ir = 1; cyc(); ev_ir = 0; idle(3);
        rd_chk("R8 IR status", 8'h00, 8'h20);
        check("R8 wake masked", {31'b0, wake}, 0);
        wr(8'h02, 8'h23);
        check("R8 wake after enable", {31'b0, wake}, 1);
        wr(8'h02, 8'hFF);
        rd_chk("R6 enable mask", 8'h02, 8'h23);
        wr(8'h02, 8'h00);
        rd_chk("R6 enable zero", 8'h02, 8'h00);
        check("R7 all disabled", {31'b0, wake}, 0);
        wr(8'h00, 8'hFF);
        wr(8'h02, 8'h03);

        // R5 clear coincides with detected edge
        ev_codec = 1; cyc(); ev_codec = 0; cyc();
        wr(8'h00, 8'h01);
        rd_chk("R5 edge wins", 8'h00, 8'h01);
        check("R5 wake", {31'b0, wake}, 1);
        wr(8'h00, 8'h01);

        // R9 configuration
        wr(8'h01, 8'hFF);
        rd_chk("R9 cfg mask", 8'h01, 8'h03);
        check("R9 bank out", {30'b0, bank_sel}, 3);

        // R10 bank gating
        wr(8'h01, 8'h00);
        wr(8'h10, 8'hA5);
        rd_chk("R10 locked read", 8'h10, 8'h00);
        check("R10 locked write", ir_bank, 0);
        wr(8'h01, 8'h01);
        wr(8'h11, 8'h5A);
        rd_chk("R10 open read", 8'h11, 8'h5A);
        check("R10 out byte", {24'b0, ir_bank[15:8]}, 32'h5A);
        wr(8'h01, 8'h02);
        rd_chk("R10 other bank", 8'h11, 8'h00);
        rd_chk("R2 unmapped", 8'h07, 8'h00);

        // mixed random traffic against the model
        for (int n = 0; n < 400; n++) begin
            int k;
            ev_codec = ($urandom_range(0, 9) == 0);
            ev_ring  = ($urandom_range(0, 7) == 0);
            ev_ir    = ($urandom_range(0, 11) == 0);
            we = ($urandom_range(0, 3) == 0);
            k = $urandom_range(0, 8);
            addr = (k < 3) ? 8'(k) : (k < 7) ? 8'(8'h10 + k - 3) : 8'h20;
            wdata = 8'($urandom);
            cyc();
        end
        we = 0; ev_codec = 0; ev_ring = 0; ev_ir = 0;
        idle(4);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule